// File: doc/BRIEF.md
# Timer-Counter with Locked Configuration

This block is a general-purpose timer-counter with a small register port. The register port accepts 32-bit words. Software picks the counter width (8, 16 or 32 bits), the counting direction, a one-shot option, a clock divider and a restart policy. It then sets the enable bit and the counter runs. Two channels share the counter. Each channel either compares the count against a stored value to drive a waveform pin, or captures the count when its input pin rises. Either path can be inverted per channel.

While the block is enabled, the fields that shape the count are frozen. Writes to those fields are dropped without an error. A write that turns the block on may carry new field values in the same word. A write that turns it off cannot change those fields; they become writable again on the next write. A soft-reset bit returns every register to its reset value.

Top module: `tcx_top`

## Requirements
- R1: After reset every register reads 0, which selects 16-bit width (width code 0), divide by 1, restart policy 0, all channels in compare mode, no inversion, and the counter stopped at 0.
- R2: Address 0 holds enable in bit 0, soft reset in bit 1, width in bits 3:2, divider select in bits 6:4, restart policy in bits 8:7, and capture enables in bits 10:9. While enable is 1, writes leave bits 10:2 unchanged and a read returns the kept values. Enable itself stays writable.
- R3: While enabled, writes to the waveform register (address 1, bits 1:0), the inversion register (address 2, one bit per channel) and the event register (address 3, bit 0) are ignored.
- R4: A write to address 0 that moves enable from 0 to 1 stores the locked fields carried in that same word.
- R5: A write that clears enable leaves the locked fields as they were; a later write with enable 0 changes them.
- R6: A write with bit 1 set at address 0 returns all registers, the count and the capture values to 0 one cycle later, whatever the other bits in that word are; bit 1 reads as 0.
- R7: Width codes are 0 = 16 bits, 1 = 8 bits, 2 = 32 bits, 3 = 16 bits. Counting up wraps from the width's maximum (TOP) to 0. The count never exceeds TOP.
- R8: Address 4 bit 1 selects counting down. Enabling then loads TOP, the count decrements, and it wraps from 0 back to TOP. Address 4 bit 0 selects one-shot. Address 4 may be written at any time.
- R9: Divider select 0..7 gives divide ratios 1, 2, 4, 8, 16, 64, 256 and 1024. The first step comes N cycles after the enable load, and later steps come every N cycles.
- R10: Restart policy 1 restarts on the divided tick after the count reaches its end value. Policies 0 and 3 restart on the next clock. Policy 2 also restarts on the next clock and clears the divider phase.
- R11: In one-shot mode the count returns to its start value at the restart and then halts. Address 4 bit 8 reads 1 while halted. A new enable clears the halt.
- R12: A channel with its capture enable set copies the count into its compare/capture register (address 6 + channel) on a rising edge of pin XOR invert, while running.
- R13: Waveform mode 1 drives (count < compare) on the channel pin. Mode 0 toggles the pin on each counter step taken at count == compare, starting low at enable. Modes 2 and 3 drive low. The invert bit flips the pin.
- R14: With event register bit 0 set, a divided tick advances the count only while `evt_in` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_in | input | 1 | Count-gate input used when event gating is on |
| cap_in | input | 2 | Per-channel capture pins |
| wave_out | output | 2 | Per-channel waveform pins |

## Verification
Random register traffic mixes enable changes with writes to the frozen fields. Every word is checked against a model of the lock. A design that compared against the new enable instead of the stored one would let a disabling write slip new fields in. The bench times the end of a count under all three restart policies with a divider of 4. A design that mixed these policies up would show the end value for the wrong number of cycles, or take the first step after the restart at the wrong point in the divider phase. It also checks that one-shot halts at the start value rather than at TOP. It checks that a falling capture pin, or a rising one with inversion set, hits or misses the capture as specified.

// File: rtl/tcx_pkg.sv
package tcx_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_WAVE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DRV   = 3'd2;
  localparam logic [ADDR_W-1:0] A_EVT   = 3'd3;
  localparam logic [ADDR_W-1:0] A_OPT   = 3'd4;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd5;
  localparam logic [ADDR_W-1:0] A_CC0   = 3'd6;

  typedef enum logic [1:0] {W16 = 2'd0, W8 = 2'd1, W32 = 2'd2, W16B = 2'd3} width_e;
  typedef enum logic [1:0] {RS_CLK = 2'd0, RS_TICK = 2'd1, RS_RESYNC = 2'd2, RS_CLKB = 2'd3} rsync_e;
  typedef enum logic [1:0] {WG_TOGGLE = 2'd0, WG_PWM = 2'd1, WG_LOWA = 2'd2, WG_LOWB = 2'd3} wgen_e;

  // divider select -> log2 of ratio
  function automatic logic [3:0] psel_shift(input logic [2:0] sel);
    logic [3:0] s;
    case (sel)
      3'd0: s = 4'd0;
      3'd1: s = 4'd1;
      3'd2: s = 4'd2;
      3'd3: s = 4'd3;
      3'd4: s = 4'd4;
      3'd5: s = 4'd6;
      3'd6: s = 4'd8;
      default: s = 4'd10;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/tcx_rst_sync.sv
module tcx_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/tcx_cfg.sv
module tcx_cfg
  import tcx_pkg::*;
#(
  parameter  int unsigned CH = 2,
  localparam int unsigned WI = 9 + CH,
  localparam int unsigned PB = WI - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WI-1:0]     wd_i,
  output logic              en_o,
  output width_e            mode_o,
  output logic [2:0]        psel_o,
  output rsync_e            rsync_o,
  output logic [CH-1:0]     capen_o,
  output wgen_e             wgen_o,
  output logic [CH-1:0]     inven_o,
  output logic              evgate_o,
  output logic              oneshot_o,
  output logic              down_o,
  output logic              srst_o
);
  logic          en_q, en_d;
  logic [PB-1:0] prot_q, prot_d;
  logic [1:0]    wgen_q, wgen_d;
  logic [CH-1:0] inven_q, inven_d;
  logic          evg_q, evg_d;
  logic          oneshot_q, oneshot_d;
  logic          down_q, down_d;
  logic          unlocked;

  assign unlocked = !en_q;
  assign srst_o   = wr_i && (addr_i == A_CTRL) && wd_i[1];

  always_comb begin
    en_d      = en_q;
    prot_d    = prot_q;
    wgen_d    = wgen_q;
    inven_d   = inven_q;
    evg_d     = evg_q;
    oneshot_d = oneshot_q;
    down_d    = down_q;
    if (wr_i) begin
      case (addr_i)
        A_CTRL: begin
          en_d = wd_i[0];
          if (unlocked) prot_d = wd_i[WI-1:2];
        end
        A_WAVE: if (unlocked) wgen_d  = wd_i[1:0];
        A_DRV:  if (unlocked) inven_d = wd_i[CH-1:0];
        A_EVT:  if (unlocked) evg_d   = wd_i[0];
        A_OPT: begin
          oneshot_d = wd_i[0];
          down_d    = wd_i[1];
        end
        default: ;
      endcase
    end
    if (srst_o) begin
      en_d      = 1'b0;
      prot_d    = '0;
      wgen_d    = '0;
      inven_d   = '0;
      evg_d     = 1'b0;
      oneshot_d = 1'b0;
      down_d    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      prot_q    <= '0;
      wgen_q    <= '0;
      inven_q   <= '0;
      evg_q     <= 1'b0;
      oneshot_q <= 1'b0;
      down_q    <= 1'b0;
    end else begin
      en_q      <= en_d;
      prot_q    <= prot_d;
      wgen_q    <= wgen_d;
      inven_q   <= inven_d;
      evg_q     <= evg_d;
      oneshot_q <= oneshot_d;
      down_q    <= down_d;
    end
  end

  assign en_o      = en_q;
  assign mode_o    = width_e'(prot_q[1:0]);
  assign psel_o    = prot_q[4:2];
  assign rsync_o   = rsync_e'(prot_q[6:5]);
  assign capen_o   = prot_q[7 +: CH];
  assign wgen_o    = wgen_e'(wgen_q);
  assign inven_o   = inven_q;
  assign evgate_o  = evg_q;
  assign oneshot_o = oneshot_q;
  assign down_o    = down_q;

  // R2
  ctrl_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !srst_o) |=> $stable(prot_q));

  // R3
  side_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !srst_o) |=> ($stable(wgen_q) && $stable(inven_q) && $stable(evg_q)));

  // R6
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> (!en_q && prot_q == '0 && wgen_q == '0 && !oneshot_q && !down_q));
endmodule

// File: rtl/tcx_core.sv
module tcx_core
  import tcx_pkg::*;
#(
  parameter  int unsigned DW = 32,
  localparam int unsigned PW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          en_i,
  input  width_e        mode_i,
  input  logic [2:0]    psel_i,
  input  rsync_e        rsync_i,
  input  logic          evgate_i,
  input  logic          evt_i,
  input  logic          oneshot_i,
  input  logic          down_i,
  output logic [DW-1:0] count_o,
  output logic          run_o,
  output logic          load_o,
  output logic          step_o,
  output logic          stopped_o
);
  logic [DW-1:0] count_q, count_d;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          en_d_q, en_d_d;
  logic          stop_q, stop_d;
  logic [DW-1:0] top_w, start_w, term_w;
  logic [PW-1:0] div_m1;
  logic          tick_w, run_w, load_w, at_term, adv_w, imm_w;

  always_comb begin
    case (mode_i)
      W8:      top_w = {DW{1'b1}} >> (DW - 8);
      W32:     top_w = {DW{1'b1}};
      default: top_w = {DW{1'b1}} >> (DW - 16);
    endcase
  end

  assign start_w = down_i ? top_w : '0;
  assign term_w  = down_i ? '0 : top_w;
  assign div_m1  = (PW'(1) << psel_shift(psel_i)) - PW'(1);
  assign tick_w  = (pcnt_q == div_m1);
  assign run_w   = en_i && en_d_q;
  assign load_w  = en_i && !en_d_q;
  assign at_term = run_w && !stop_q && (count_q == term_w);
  assign adv_w   = run_w && !stop_q && tick_w && (!evgate_i || evt_i);
  assign imm_w   = (rsync_i != RS_TICK);

  always_comb begin
    en_d_d  = en_i;
    count_d = count_q;
    pcnt_d  = pcnt_q;
    stop_d  = stop_q;
    if (load_w) begin
      count_d = start_w;
      pcnt_d  = '0;
      stop_d  = 1'b0;
    end else if (run_w) begin
      pcnt_d = tick_w ? '0 : pcnt_q + PW'(1);
      if (at_term && imm_w) begin
        count_d = start_w;
        stop_d  = oneshot_i;
        if (rsync_i == RS_RESYNC) pcnt_d = '0;
      end else if (adv_w) begin
        if (at_term) begin
          count_d = start_w;
          stop_d  = oneshot_i;
        end else begin
          count_d = down_i ? count_q - DW'(1) : count_q + DW'(1);
        end
      end
    end
    if (srst_i) begin
      en_d_d  = 1'b0;
      count_d = '0;
      pcnt_d  = '0;
      stop_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d_q  <= 1'b0;
      count_q <= '0;
      pcnt_q  <= '0;
      stop_q  <= 1'b0;
    end else begin
      en_d_q  <= en_d_d;
      count_q <= count_d;
      pcnt_q  <= pcnt_d;
      stop_q  <= stop_d;
    end
  end

  assign count_o   = count_q;
  assign run_o     = run_w;
  assign load_o    = load_w;
  assign step_o    = adv_w && !(at_term && imm_w);
  assign stopped_o = stop_q;

  // R7
  width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_w |-> ((count_q & ~top_w) == '0));

  // R11
  halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_w && stop_q && !srst_i) |=> $stable(count_q));
endmodule

// File: rtl/tcx_chan.sv
module tcx_chan
  import tcx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          cc_wr_i,
  input  logic [DW-1:0] cc_wd_i,
  input  logic          capen_i,
  input  logic          inven_i,
  input  wgen_e         wgen_i,
  input  logic          run_i,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [DW-1:0] count_i,
  input  logic          pin_i,
  output logic [DW-1:0] cc_o,
  output logic          wave_o
);
  logic [DW-1:0] cc_q, cc_d;
  logic          lvl_q, lvl_w, rise_w;
  logic          tog_q, tog_d;
  logic          raw_w;

  assign lvl_w  = pin_i ^ inven_i;
  assign rise_w = lvl_w && !lvl_q;

  always_comb begin
    cc_d  = cc_q;
    tog_d = tog_q;
    if (cc_wr_i)                        cc_d = cc_wd_i;
    else if (capen_i && run_i && rise_w) cc_d = count_i;
    if (load_i)                                             tog_d = 1'b0;
    else if (step_i && !capen_i && (count_i == cc_q))       tog_d = !tog_q;
    if (srst_i) begin
      cc_d  = '0;
      tog_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q  <= '0;
      tog_q <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      cc_q  <= cc_d;
      tog_q <= tog_d;
      lvl_q <= lvl_w;
    end
  end

  always_comb begin
    if (capen_i) raw_w = 1'b0;
    else begin
      case (wgen_i)
        WG_TOGGLE: raw_w = tog_q;
        WG_PWM:    raw_w = (count_i < cc_q);
        default:   raw_w = 1'b0;
      endcase
    end
  end

  assign wave_o = raw_w ^ inven_i;
  assign cc_o   = cc_q;

  // R12
  cap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capen_i && run_i && rise_w && !cc_wr_i && !srst_i) |=> (cc_q == $past(count_i)));
endmodule

// File: rtl/tcx_top.sv
module tcx_top
  import tcx_pkg::*;
#(
  parameter int unsigned CH = 2,
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              evt_in,
  input  logic [CH-1:0]     cap_in,
  output logic [CH-1:0]     wave_out
);
  localparam int unsigned WI = 9 + CH;

  logic          rst_sn;
  logic          en_w, evg_w, one_w, down_w, srst_w;
  width_e        mode_w;
  logic [2:0]    psel_w;
  rsync_e        rsync_w;
  logic [CH-1:0] capen_w, inven_w;
  wgen_e         wgen_w;
  logic [DW-1:0] count_w;
  logic          run_w, load_w, step_w, stop_w;
  logic [DW-1:0] cc_w [CH];

  tcx_rst_sync u_rst (
    .clk_i (clk),
    .rst_ni(rst_n),
    .rst_no(rst_sn)
  );

  tcx_cfg #(.CH(CH)) u_cfg (
    .clk_i    (clk),
    .rst_ni   (rst_sn),
    .wr_i     (reg_wr),
    .addr_i   (reg_addr),
    .wd_i     (reg_wdata[WI-1:0]),
    .en_o     (en_w),
    .mode_o   (mode_w),
    .psel_o   (psel_w),
    .rsync_o  (rsync_w),
    .capen_o  (capen_w),
    .wgen_o   (wgen_w),
    .inven_o  (inven_w),
    .evgate_o (evg_w),
    .oneshot_o(one_w),
    .down_o   (down_w),
    .srst_o   (srst_w)
  );

  tcx_core #(.DW(DW)) u_core (
    .clk_i    (clk),
    .rst_ni   (rst_sn),
    .srst_i   (srst_w),
    .en_i     (en_w),
    .mode_i   (mode_w),
    .psel_i   (psel_w),
    .rsync_i  (rsync_w),
    .evgate_i (evg_w),
    .evt_i    (evt_in),
    .oneshot_i(one_w),
    .down_i   (down_w),
    .count_o  (count_w),
    .run_o    (run_w),
    .load_o   (load_w),
    .step_o   (step_w),
    .stopped_o(stop_w)
  );

  for (genvar g = 0; g < CH; g++) begin : g_chan
    tcx_chan #(.DW(DW)) u_chan (
      .clk_i  (clk),
      .rst_ni (rst_sn),
      .srst_i (srst_w),
      .cc_wr_i(reg_wr && (reg_addr == A_CC0 + ADDR_W'(g))),
      .cc_wd_i(reg_wdata[DW-1:0]),
      .capen_i(capen_w[g]),
      .inven_i(inven_w[g]),
      .wgen_i (wgen_w),
      .run_i  (run_w),
      .load_i (load_w),
      .step_i (step_w),
      .count_i(count_w),
      .pin_i  (cap_in[g]),
      .cc_o   (cc_w[g]),
      .wave_o (wave_out[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = 32'({capen_w, rsync_w, psel_w, mode_w, 1'b0, en_w});
      A_WAVE:  reg_rdata = 32'(wgen_w);
      A_DRV:   reg_rdata = 32'(inven_w);
      A_EVT:   reg_rdata = 32'(evg_w);
      A_OPT:   reg_rdata = 32'({stop_w, 6'd0, down_w, one_w});
      A_COUNT: reg_rdata = 32'(count_w);
      default: begin
        for (int i = 0; i < CH; i++) begin
          if (reg_addr == A_CC0 + ADDR_W'(i)) reg_rdata = 32'(cc_w[i]);
        end
      end
    endcase
  end
endmodule

// File: tb/tcx_top_tb_top.sv
`timescale 1ns/1ps
module tcx_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        evt_in;
  logic [1:0]  cap_in;
  logic [1:0]  wave_out;

  int n_chk = 0;
  int n_bad = 0;
  int cur_m = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  tcx_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .cap_in(cap_in), .wave_out(wave_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic rchk(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  // disable, set option word, then enable with the given field word
  task automatic go(input logic [31:0] fields, input logic [31:0] opt);
    wr(3'd0, 32'h0);
    wr(3'd4, opt);
    wr(3'd0, fields | 32'h1);
    cur_m = -1;
  endtask

  task automatic goto_m(input int m);
    repeat (m - cur_m) @(negedge clk);
    cur_m = m;
  endtask

  function automatic logic [31:0] lock_ctrl(input logic [31:0] cur, input logic [31:0] d);
    if (cur[0]) return {cur[31:1], d[0]};
    return d & 32'h7FD;
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_up();
  end

  initial begin
    logic [31:0] m_ctrl, m_wave, m_drv, m_evt, d;
    logic [2:0]  a;
    int          seed;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    evt_in = 1'b0; cap_in = 2'b00;
    seed = $urandom(32'h5EED_1234);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rchk("R1 ctrl", 3'd0, 32'h0);
    rchk("R1 wave", 3'd1, 32'h0);
    rchk("R1 drv", 3'd2, 32'h0);
    rchk("R1 opt", 3'd4, 32'h0);
    rchk("R1 count", 3'd5, 32'h0);
    rchk("R1 cc0", 3'd6, 32'h0);

    // R2 R3 random lock traffic against a model
    m_ctrl = 0; m_wave = 0; m_drv = 0; m_evt = 0;
    for (int i = 0; i < 80; i++) begin
      a = 3'($urandom_range(0, 3));
      d = $urandom() & 32'hFFFF_FFFD;
      case (a)
        3'd0: m_ctrl = lock_ctrl(m_ctrl, d);
        3'd1: if (!m_ctrl[0]) m_wave = d & 32'h3;
        3'd2: if (!m_ctrl[0]) m_drv  = d & 32'h3;
        default: if (!m_ctrl[0]) m_evt = d & 32'h1;
      endcase
      wr(a, d);
      rchk("R2 ctrl lock", 3'd0, m_ctrl);
      rchk("R3 wave lock", 3'd1, m_wave);
      rchk("R3 drv lock", 3'd2, m_drv);
      rchk("R3 evt lock", 3'd3, m_evt);
    end

    // R4 / R5 directed
    wr(3'd0, 32'h0); wr(3'd0, 32'h0);
    wr(3'd0, 32'h35);
    rchk("R4 commit on enable", 3'd0, 32'h35);
    wr(3'd0, 32'h08);
    rchk("R5 disable keeps fields", 3'd0, 32'h34);
    wr(3'd0, 32'h08);
    rchk("R5 later write lands", 3'd0, 32'h08);
    wr(3'd1, 32'h0); wr(3'd2, 32'h0); wr(3'd3, 32'h0);

    // R6 soft reset wins over other bits
    wr(3'd1, 32'h1); wr(3'd2, 32'h3); wr(3'd4, 32'h3); wr(3'd6, 32'd55);
    wr(3'd0, 32'h1);
    repeat (20) @(negedge clk);
    wr(3'd0, 32'h7);
    rchk("R6 ctrl", 3'd0, 32'h0);
    rchk("R6 wave", 3'd1, 32'h0);
    rchk("R6 drv", 3'd2, 32'h0);
    rchk("R6 opt", 3'd4, 32'h0);
    rchk("R6 cc0", 3'd6, 32'h0);
    rchk("R6 count", 3'd5, 32'h0);

    // R7 width 8 up, restart policy 1
    go(32'h84, 32'h0);
    goto_m(100); rchk("R7 8b mid", 3'd5, 32'd100);
    goto_m(255); rchk("R7 8b top", 3'd5, 32'd255);
    goto_m(256); rchk("R7 8b wrap", 3'd5, 32'd0);
    go(32'h80, 32'h0);
    goto_m(300); rchk("R7 16b", 3'd5, 32'd300);
    go(32'h8C, 32'h0);
    goto_m(300); rchk("R7 code3 16b", 3'd5, 32'd300);

    // R8 down counting
    go(32'h84, 32'h2);
    goto_m(0);   rchk("R8 load top", 3'd5, 32'd255);
    goto_m(255); rchk("R8 reach 0", 3'd5, 32'd0);
    goto_m(256); rchk("R8 wrap top", 3'd5, 32'd255);
    go(32'h88, 32'h2);
    goto_m(5);   rchk("R8 32b down", 3'd5, 32'hFFFF_FFFA);
    go(32'h80, 32'h2);
    goto_m(7);   rchk("R8 16b down", 3'd5, 32'h0000_FFF8);

    // R9 divider ratios
    for (int s = 0; s < 8; s++) begin
      int n;
      n = (s < 5) ? (1 << s) : (s == 5) ? 64 : (s == 6) ? 256 : 1024;
      go(32'h80 | (32'(s) << 4), 32'h0);
      if (n > 1) begin
        goto_m(n - 1); rchk("R9 before first step", 3'd5, 32'd0);
      end
      goto_m(3 * n + n / 2); rchk("R9 steps", 3'd5, 32'd3);
    end

    // R10 restart policies, 8 bit, divide by 4
    go(32'h4 | 32'h20 | (32'd1 << 7), 32'h0);
    goto_m(1020); rchk("R10 p1 end", 3'd5, 32'd255);
    goto_m(1021); rchk("R10 p1 held", 3'd5, 32'd255);
    goto_m(1024); rchk("R10 p1 restart", 3'd5, 32'd0);
    go(32'h4 | 32'h20 | (32'd0 << 7), 32'h0);
    goto_m(1021); rchk("R10 p0 restart", 3'd5, 32'd0);
    goto_m(1024); rchk("R10 p0 phase kept", 3'd5, 32'd1);
    go(32'h4 | 32'h20 | (32'd2 << 7), 32'h0);
    goto_m(1021); rchk("R10 p2 restart", 3'd5, 32'd0);
    goto_m(1024); rchk("R10 p2 phase cleared", 3'd5, 32'd0);
    goto_m(1025); rchk("R10 p2 first step", 3'd5, 32'd1);

    // R11 one-shot
    go(32'h84, 32'h1);
    goto_m(255); rchk("R11 top", 3'd5, 32'd255);
    goto_m(256); rchk("R11 back to start", 3'd5, 32'd0);
    goto_m(300); rchk("R11 halted", 3'd5, 32'd0);
    rchk("R11 halt flag", 3'd4, 32'h101);
    wr(3'd0, 32'h0); wr(3'd0, 32'h85); cur_m = -1;
    goto_m(10); rchk("R11 re-enable runs", 3'd5, 32'd10);
    rchk("R11 flag cleared", 3'd4, 32'h1);

    // R14 event gating
    wr(3'd0, 32'h0); wr(3'd3, 32'h1);
    go(32'h80, 32'h0);
    goto_m(20); rchk("R14 no event no step", 3'd5, 32'd0);
    evt_in = 1'b1;
    repeat (7) @(negedge clk);
    evt_in = 1'b0;
    repeat (5) @(negedge clk);
    rchk("R14 steps only with event", 3'd5, 32'd7);
    wr(3'd0, 32'h0); wr(3'd3, 32'h0);

    // R12 capture with and without inversion
    wr(3'd6, 32'd0); wr(3'd7, 32'd0);
    cap_in = 2'b10;
    wr(3'd2, 32'h2);
    go(32'h80 | 32'h600, 32'h0);
    goto_m(40); cap_in[0] = 1'b1;
    goto_m(60); cap_in[1] = 1'b0;
    goto_m(70); cap_in[0] = 1'b0;
    goto_m(80);
    rchk("R12 capture ch0", 3'd6, 32'd40);
    rchk("R12 inverted capture ch1", 3'd7, 32'd60);
    rchk("R12 counter still runs", 3'd5, 32'd80);
    cap_in = 2'b00;
    wr(3'd0, 32'h0); wr(3'd0, 32'h0); wr(3'd2, 32'h0);

    // R13 PWM with inversion on ch1
    wr(3'd1, 32'h1); wr(3'd2, 32'h2);
    wr(3'd6, 32'd10); wr(3'd7, 32'd10);
    go(32'h84, 32'h0);
    goto_m(5);  check("R13 pwm below", 32'(wave_out), 32'h1);
    goto_m(12); check("R13 pwm above", 32'(wave_out), 32'h2);
    // R13 toggle mode
    wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd2, 32'h0);
    wr(3'd6, 32'd3);
    go(32'h84, 32'h0);
    goto_m(3);   check("R13 toggle before", 32'(wave_out), 32'h0);
    goto_m(4);   check("R13 toggle after match", 32'(wave_out), 32'h1);
    goto_m(11);  check("R13 ch1 toggles", 32'(wave_out), 32'h3);
    goto_m(200); check("R13 toggle holds", 32'(wave_out), 32'h3);
    wr(3'd0, 32'h0); wr(3'd1, 32'h2);
    wr(3'd0, 32'h85);
    repeat (5) @(negedge clk);
    check("R13 mode2 low", 32'(wave_out), 32'h0);

    finish_up();
  end
endmodule